// File: doc/BRIEF.md
# Collision and Heartbeat Indicator for a 10 Mb/s Transceiver

This block drives the single collision line that a 10 Mb/s twisted-pair transceiver presents to its MAC. Three things can raise that line: a real collision (the local transmitter and receiver are busy at the same time while the link runs half duplex), a jabber condition flagged by the transmit watchdog elsewhere, and a short signal-quality-error pulse. That pulse is sent a fixed time after each transmission ends and tells the MAC that the collision path works. Real collisions and jabber reach the output through logic only, with no register in the path. The heartbeat pulse comes from a small counter sequencer.

The block runs on a 20 MHz clock, which gives two ticks per bit time, and has a synchronous active-high reset. With the default parameters, the heartbeat starts about 1 µs after transmission ends (20 clocks) and lasts about 10 bit times (20 clocks). When the link is full duplex, the heartbeat is suppressed and overlapping transmit and receive is not a collision. A separate disable input also turns the heartbeat off.

Top module: `col_sqe_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `col_out` is low unless `jabber` or a half-duplex overlap drives it. A heartbeat that was pending when reset arrived is discarded.
- R2: When `fdx_mode` is 0 and both `tx_busy` and `rx_busy` are 1, `col_out` is 1 in that same cycle, with no clock edge between input and output.
- R3: When `fdx_mode` is 1, `tx_busy` and `rx_busy` both being high never raises `col_out`.
- R4: When `jabber` is 1, `col_out` is 1 in that same cycle, in either duplex mode.
- R5: Let E0 be the first clock edge that samples `tx_busy` low after an edge that sampled it high, with the heartbeat allowed at E0. Then `col_out` goes high just after edge E0+HB_DELAY and stays high for exactly HB_WIDTH cycles.
- R6: The heartbeat is allowed only when `fdx_mode` is 0 and `hb_off` is 0. If either is sampled high at E0, no pulse is produced. If either is sampled high at any edge while a heartbeat is pending or being sent, that heartbeat is cancelled.
- R7: If `tx_busy` is sampled high at any edge during the heartbeat delay or the pulse, that heartbeat is cancelled, and `col_out` falls one cycle later unless another source holds it.
- R8: `col_out` is the OR of the heartbeat pulse, the half-duplex overlap and `jabber`. A source that asserts during a heartbeat pulse keeps the line high, and the pulse timing is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_busy | input | 1 | Local transmitter is sending |
| rx_busy | input | 1 | Valid receive data is present |
| jabber | input | 1 | Jabber condition is active |
| fdx_mode | input | 1 | 1 = full duplex, 0 = half duplex |
| hb_off | input | 1 | 1 = heartbeat disabled |
| col_out | output | 1 | Collision indication to the MAC |

## Verification
The bench builds the block with HB_DELAY=6 and HB_WIDTH=4 instead of the 20/20 defaults. With these values a whole heartbeat fits in about a dozen cycles. This lets the bench cancel it at the first and last cycle of the delay and of the pulse, and rerun each scenario under every gating combination, without long idle stretches. The counter compare and the width derivation are the same code paths the defaults use. The bench model tracks the time since transmission ended as a plain integer and checks `col_out` every cycle.

// File: rtl/col_sqe_pkg.sv
package col_sqe_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_e;

  // Heartbeat may run only in half duplex with the disable input clear.
  function automatic logic hb_allowed(input logic fdx, input logic off);
    return !fdx && !off;
  endfunction

  // Half-duplex overlap of the two channels.
  function automatic logic overlap_hit(input logic fdx, input logic tx, input logic rx);
    return !fdx && tx && rx;
  endfunction

  // Counter width needed to count 0..n-1, minimum 1 bit.
  function automatic int span_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/col_src_merge.sv
module col_src_merge (
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic jabber,
  input  logic fdx_mode,
  input  logic hb_pulse,
  output logic real_col,
  output logic col_out
);
  import col_sqe_pkg::*;

  always_comb begin
    real_col = jabber | overlap_hit(fdx_mode, tx_busy, rx_busy);
    col_out  = real_col | hb_pulse;
  end
endmodule

// File: rtl/hb_sequencer.sv
module hb_sequencer #(
  parameter int HB_DELAY = 20,
  parameter int HB_WIDTH = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic fdx_mode,
  input  logic hb_off,
  output logic tx_fall,
  output logic hb_pending,
  output logic hb_pulse
);
  import col_sqe_pkg::*;

  localparam int MAXC  = (HB_DELAY > HB_WIDTH) ? HB_DELAY : HB_WIDTH;
  localparam int CNT_W = span_bits(MAXC);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(HB_DELAY - 1);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(HB_WIDTH - 1);

  hb_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             tx_d;
  logic             en;

  always_comb begin
    en         = hb_allowed(fdx_mode, hb_off);
    tx_fall    = tx_d && !tx_busy;
    hb_pending = (st == HB_WAIT);
    hb_pulse   = (st == HB_PULSE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= HB_IDLE;
      cnt  <= '0;
      tx_d <= 1'b0;
    end else begin
      tx_d <= tx_busy;
      if (tx_fall && en) begin
        st  <= HB_WAIT;
        cnt <= '0;
      end else if (tx_busy || !en) begin
        st  <= HB_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          HB_WAIT: begin
            if (cnt == LAST_D) begin
              st  <= HB_PULSE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          HB_PULSE: begin
            if (cnt == LAST_W) begin
              st  <= HB_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            st  <= HB_IDLE;
            cnt <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/col_sqe_gen.sv
module col_sqe_gen #(
  parameter int HB_DELAY = 20,
  parameter int HB_WIDTH = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic jabber,
  input  logic fdx_mode,
  input  logic hb_off,
  output logic col_out
);

  logic tx_fall;
  logic hb_pending;
  logic hb_pulse;
  logic real_col;

  hb_sequencer #(
    .HB_DELAY(HB_DELAY),
    .HB_WIDTH(HB_WIDTH)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tx_busy   (tx_busy),
    .fdx_mode  (fdx_mode),
    .hb_off    (hb_off),
    .tx_fall   (tx_fall),
    .hb_pending(hb_pending),
    .hb_pulse  (hb_pulse)
  );

  col_src_merge u_merge (
    .tx_busy (tx_busy),
    .rx_busy (rx_busy),
    .jabber  (jabber),
    .fdx_mode(fdx_mode),
    .hb_pulse(hb_pulse),
    .real_col(real_col),
    .col_out (col_out)
  );
endmodule

// File: rtl/col_sqe_gen_chk.sv
module col_sqe_gen_chk (
  input logic clk,
  input logic rst,
  input logic tx_busy,
  input logic rx_busy,
  input logic jabber,
  input logic fdx_mode,
  input logic hb_off,
  input logic col_out,
  input logic tx_fall,
  input logic hb_pending,
  input logic hb_pulse,
  input logic real_col
);

  AST_HDX_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    (!fdx_mode && tx_busy && rx_busy) |-> col_out);                          // R2

  AST_FDX_SILENT: assert property (@(posedge clk) disable iff (rst)
    (fdx_mode && !jabber && !hb_pulse) |-> !col_out);                        // R3

  AST_JABBER_COL: assert property (@(posedge clk) disable iff (rst)
    jabber |-> col_out);                                                     // R4

  AST_PULSE_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(hb_pulse) |-> $past(hb_pending));                                  // R5

  AST_WAIT_FROM_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(hb_pending) |-> $past(tx_fall));                                   // R5

  AST_GATE_STOPS_HB: assert property (@(posedge clk) disable iff (rst)
    (fdx_mode || hb_off) |=> (!hb_pulse && !hb_pending));                   // R6

  AST_TX_CANCELS: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> !hb_pulse);                                                  // R7

  AST_OR_MERGE: assert property (@(posedge clk) disable iff (rst)
    (hb_pulse || real_col) |-> col_out);                                     // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!hb_pulse && !hb_pending));                                     // R1

endmodule

bind col_sqe_gen col_sqe_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_busy   (tx_busy),
  .rx_busy   (rx_busy),
  .jabber    (jabber),
  .fdx_mode  (fdx_mode),
  .hb_off    (hb_off),
  .col_out   (col_out),
  .tx_fall   (tx_fall),
  .hb_pending(hb_pending),
  .hb_pulse  (hb_pulse),
  .real_col  (real_col)
);

// File: tb/sim_col_sqe_gen.sv
`timescale 1ns/1ps
module sim_col_sqe_gen;
  localparam int D = 6;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx = 1'b0, rx = 1'b0, jab = 1'b0, fdx = 1'b0, off = 1'b0;
  logic col;

  int total = 0;
  int bad = 0;
  int t_since = -1;   // edges since the transmit-end edge, -1 = none
  logic prev_tx = 1'b0;

  always #2.5 clk = ~clk;

  col_sqe_gen #(.HB_DELAY(D), .HB_WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .tx_busy(tx), .rx_busy(rx), .jabber(jab),
    .fdx_mode(fdx), .hb_off(off), .col_out(col)
  );

  // Behavioural reference: time since transmission ended.
  always @(posedge clk) begin
    if (rst) begin
      t_since = -1;
      prev_tx = 1'b0;
    end else begin
      if (prev_tx && !tx && !fdx && !off) t_since = 0;
      else if (tx || fdx || off) t_since = -1;
      else if (t_since >= 0) begin
        t_since = t_since + 1;
        if (t_since >= D + W) t_since = -1;
      end
      prev_tx = tx;
    end
  end

  function automatic logic expect_col();
    logic hb;
    hb = (t_since >= D) && (t_since < D + W);
    return jab | (!fdx & tx & rx) | hb;
  endfunction

  task automatic cyc(input logic r, input logic t, input logic x, input logic j,
                     input logic f, input logic o, input string req);
    @(negedge clk);
    rst = r; tx = t; rx = x; jab = j; fdx = f; off = o;
    #1;
    total++;
    if (col !== expect_col()) begin
      bad++;
      $display("FAIL %s: col_out=%0b expected=%0b at %0t", req, col, expect_col(), $time);
    end
  endtask

  task automatic idle(input int n, input logic f, input logic o, input string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, f, o, req);
  endtask

  task automatic send(input int n, input logic f, input logic o, input string req);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, f, o, req);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, "R1");
    idle(2, 0, 0, "R1");

    // R2 half-duplex overlap, plus single-channel activity
    cyc(0, 1, 0, 0, 0, 0, "R2");
    cyc(0, 1, 1, 0, 0, 0, "R2");
    cyc(0, 1, 1, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, 0, "R2");
    idle(D + W + 2, 0, 0, "R5");

    // R5 full heartbeat after a transmission
    send(4, 0, 0, "R5");
    idle(D + W + 3, 0, 0, "R5");

    // R3 full duplex overlap, and R6 no heartbeat in full duplex
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 1, 0, "R3");
    idle(D + W + 2, 1, 0, "R6");

    // R6 disable input at the end of transmission
    send(3, 0, 1, "R6");
    idle(D + W + 2, 0, 1, "R6");
    // R6 disable raised mid-delay, and mid-pulse
    send(3, 0, 0, "R6");
    idle(2, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, "R6");
    idle(D + W, 0, 0, "R6");
    send(3, 0, 0, "R6");
    idle(D + 2, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, 0, "R6");
    idle(W + 2, 0, 0, "R6");

    // R4 jabber in both modes
    cyc(0, 0, 0, 1, 0, 0, "R4");
    cyc(0, 1, 0, 1, 1, 0, "R4");
    cyc(0, 0, 0, 1, 1, 1, "R4");
    idle(D + W + 2, 0, 0, "R4");

    // R7 retransmit at first and last delay cycle, first and last pulse cycle
    for (int k = 0; k < 4; k++) begin
      int gap;
      gap = (k == 0) ? 1 : (k == 1) ? D : (k == 2) ? D + 1 : D + W;
      send(2, 0, 0, "R7");
      idle(gap, 0, 0, "R7");
      send(2, 0, 0, "R7");
      idle(D + W + 2, 0, 0, "R7");
    end

    // R8 other sources during a pulse
    send(2, 0, 0, "R8");
    idle(D + 1, 0, 0, "R8");
    cyc(0, 0, 0, 1, 0, 0, "R8");
    cyc(0, 0, 1, 0, 0, 0, "R8");
    idle(W + 2, 0, 0, "R8");

    // R1 reset while a heartbeat is pending
    send(2, 0, 0, "R1");
    idle(2, 0, 0, "R1");
    cyc(1, 0, 0, 0, 0, 0, "R1");
    idle(D + W + 2, 0, 0, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule